// File: doc/BRIEF.md
# Backplane Slot Card Register Target

This block is the bus-target side of one peripheral card on a shared backplane. A decoder examines the 24-bit bus address and the read and write strobes. It drives sixteen active-low per-slot select lines, and at most one of them is low at a time. The card watches its own line, chosen by a parameter, and uses the low 16 address bits to reach a small register bank. That bank has a control word, an interrupt-pending word, an interrupt-enable word and a scratch word.

Writes land byte by byte under the per-lane write strobes. A read returns its data in the same cycle that the card raises its ready signal. Several internal event sources set pending bits. The card pulls one owned active-low interrupt line while any enabled pending bit is set. The host reads the pending word to find the cause and clears bits by writing ones.

Top module: `slot_card_target`

## Requirements
- R1: Every per-slot select is high unless address bits [23:20] equal 0x4 and at least one write lane strobe or the read strobe is high.
- R2: When R1 permits, exactly the select whose index equals address bits [19:16] is low, so slot n answers at base 0x4n0000.
- R3: The card reacts only to its own select: an access for another slot or outside the IO region changes no register and raises no ready.
- R4: A write updates only the bytes whose lane strobe is high (lane k covers data bits 8k+7..8k). The control word also appears on a port.
- R5: Read data from the addressed register is valid in the first cycle ready is high. The read output enable is high only while the card's select is low and the read strobe is high.
- R6: Ready rises one clock after the card's select goes low and stays high until the select is released. It falls one clock after that, so each access gives exactly one ready pulse and one register update.
- R7: Registers sit at offsets 0x0 control, 0x4 pending, 0x8 enable and 0xC scratch, with the full 16-bit offset compared. Any other offset reads zero and ignores writes.
- R8: Pending bits 0..NSRC-1 are set by a high event input and cleared by writing 1 to them. An event wins over a clear in the same cycle.
- R9: The interrupt line is low exactly when some pending bit and its enable bit are both set. It follows the register state on the same clock edge that updates that state.
- R10: After synchronous reset every register is zero, ready is low and the interrupt line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Bus address: region tag, slot number, register offset |
| bus_wstrb | input | 4 | Per-byte-lane write strobes |
| bus_rstrb | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data from the host |
| src_evt | input | 8 | Internal interrupt event inputs, one per pending bit |
| slot_sel_n | output | 16 | Decoded active-low per-slot selects |
| bus_ready | output | 1 | Access acknowledge from this card |
| bus_rdata | output | 32 | Registered read data |
| bus_rdata_oe | output | 1 | Read data drive enable |
| irq_n | output | 1 | Active-low interrupt owned by this card |
| ctrl_q | output | 32 | Current control word |

## Verification
A wrong pending or enable bit shows on the interrupt line at the edge that stores it. It also shows in the pending readback at the next read. A stuck sequencer state shows as a missing or doubled ready pulse within two cycles of a select. It also shows as a second write commit, which the next readback of that register exposes. A decode fault shows at once on the select lines, and it shows as registers that change under accesses meant for other slots.

// File: rtl/card_bus_pkg.sv
package card_bus_pkg;
  localparam int OFF_W = 16;
  localparam logic [OFF_W-1:0] OFF_CTRL = 16'h0000;
  localparam logic [OFF_W-1:0] OFF_PEND = 16'h0004;
  localparam logic [OFF_W-1:0] OFF_IEN  = 16'h0008;
  localparam logic [OFF_W-1:0] OFF_SCR  = 16'h000C;

  typedef enum logic {SEQ_IDLE, SEQ_HOLD} seq_state_t;
endpackage

// File: rtl/slot_decoder.sv
module slot_decoder #(
  parameter int SLOT_BITS = 4,
  parameter int TAG_W     = 4,
  parameter logic [TAG_W-1:0] IO_TAG = 4'h4,
  parameter int LANES     = 4
) (
  input  logic [TAG_W-1:0]          addr_tag,
  input  logic [SLOT_BITS-1:0]      addr_slot,
  input  logic [LANES-1:0]          wr_lanes,
  input  logic                      rd_stb,
  output logic [2**SLOT_BITS-1:0]   sel_n
);
  localparam int NSLOTS = 2**SLOT_BITS;

  logic gate_en;
  assign gate_en = (addr_tag == IO_TAG) && ((|wr_lanes) || rd_stb);

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    assign sel_n[s] = ~(gate_en && (addr_slot == SLOT_BITS'(s)));
  end
endmodule

// File: rtl/access_sequencer.sv
module access_sequencer
  import card_bus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic wr_any,
  input  logic rd_stb,
  output logic ready,
  output logic wr_commit,
  output logic rd_capture
);
  seq_state_t state;
  logic sel_on;

  assign sel_on     = ~sel_n;
  assign wr_commit  = (state == SEQ_IDLE) && sel_on && wr_any;
  assign rd_capture = (state == SEQ_IDLE) && sel_on && rd_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      ready <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: if (sel_on) begin
          state <= SEQ_HOLD;
          ready <= 1'b1;
        end
        SEQ_HOLD: if (!sel_on) begin
          state <= SEQ_IDLE;
          ready <= 1'b0;
        end
        default: begin
          state <= SEQ_IDLE;
          ready <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/card_regbank.sv
module card_regbank
  import card_bus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NSRC   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_commit,
  input  logic                rd_capture,
  input  logic [OFF_W-1:0]    offset,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] lanes,
  input  logic [NSRC-1:0]     src_evt,
  output logic [DATA_W-1:0]   rdata,
  output logic [DATA_W-1:0]   ctrl,
  output logic                irq_n
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] scr_r, lane_mask, ctrl_nx, scr_nx;
  logic [NSRC-1:0]   pend_r, ien_r, pend_nx, ien_nx, wmask_s, wbits_s;
  logic hit_ctrl, hit_pend, hit_ien, hit_scr;

  always_comb begin
    for (int l = 0; l < LANES; l++) lane_mask[l*8 +: 8] = {8{lanes[l]}};
  end

  assign hit_ctrl = wr_commit && (offset == OFF_CTRL);
  assign hit_pend = wr_commit && (offset == OFF_PEND);
  assign hit_ien  = wr_commit && (offset == OFF_IEN);
  assign hit_scr  = wr_commit && (offset == OFF_SCR);

  assign wmask_s = lane_mask[NSRC-1:0];
  assign wbits_s = wdata[NSRC-1:0] & wmask_s;

  assign ctrl_nx = hit_ctrl ? (ctrl  & ~lane_mask) | (wdata & lane_mask) : ctrl;
  assign scr_nx  = hit_scr  ? (scr_r & ~lane_mask) | (wdata & lane_mask) : scr_r;
  // events are ORed in after the clear so a coincident event survives
  assign pend_nx = (pend_r & ~(hit_pend ? wbits_s : '0)) | src_evt;
  assign ien_nx  = hit_ien ? (ien_r & ~wmask_s) | wbits_s : ien_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      scr_r  <= '0;
      pend_r <= '0;
      ien_r  <= '0;
      rdata  <= '0;
      irq_n  <= 1'b1;
    end else begin
      ctrl   <= ctrl_nx;
      scr_r  <= scr_nx;
      pend_r <= pend_nx;
      ien_r  <= ien_nx;
      irq_n  <= ~|(pend_nx & ien_nx);
      if (rd_capture) begin
        case (offset)
          OFF_CTRL: rdata <= ctrl;
          OFF_PEND: rdata <= DATA_W'(pend_r);
          OFF_IEN:  rdata <= DATA_W'(ien_r);
          OFF_SCR:  rdata <= scr_r;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/slot_card_target.sv
module slot_card_target
  import card_bus_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int SLOT_BITS = 4,
  parameter int NSRC      = 8,
  parameter int CARD_SLOT = 5,
  parameter logic [3:0] IO_TAG = 4'h4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [DATA_W/8-1:0]                bus_wstrb,
  input  logic                               bus_rstrb,
  input  logic [DATA_W-1:0]                  bus_wdata,
  input  logic [NSRC-1:0]                    src_evt,
  output logic [2**SLOT_BITS-1:0]            slot_sel_n,
  output logic                               bus_ready,
  output logic [DATA_W-1:0]                  bus_rdata,
  output logic                               bus_rdata_oe,
  output logic                               irq_n,
  output logic [DATA_W-1:0]                  ctrl_q
);
  localparam int LANES = DATA_W / 8;
  localparam int TAG_W = ADDR_W - OFF_W - SLOT_BITS;

  logic own_sel_n, wr_commit, rd_capture;

  slot_decoder #(
    .SLOT_BITS(SLOT_BITS), .TAG_W(TAG_W), .IO_TAG(TAG_W'(IO_TAG)), .LANES(LANES)
  ) u_dec (
    .addr_tag (bus_addr[ADDR_W-1 -: TAG_W]),
    .addr_slot(bus_addr[OFF_W +: SLOT_BITS]),
    .wr_lanes (bus_wstrb),
    .rd_stb   (bus_rstrb),
    .sel_n    (slot_sel_n)
  );

  assign own_sel_n    = slot_sel_n[CARD_SLOT];
  assign bus_rdata_oe = ~own_sel_n & bus_rstrb;

  access_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (own_sel_n),
    .wr_any    (|bus_wstrb),
    .rd_stb    (bus_rstrb),
    .ready     (bus_ready),
    .wr_commit (wr_commit),
    .rd_capture(rd_capture)
  );

  card_regbank #(.DATA_W(DATA_W), .NSRC(NSRC)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_commit (wr_commit),
    .rd_capture(rd_capture),
    .offset    (bus_addr[OFF_W-1:0]),
    .wdata     (bus_wdata),
    .lanes     (bus_wstrb),
    .src_evt   (src_evt),
    .rdata     (bus_rdata),
    .ctrl      (ctrl_q),
    .irq_n     (irq_n)
  );
endmodule

// File: rtl/slot_card_chk.sv
module slot_card_chk #(
  parameter int ADDR_W    = 24,
  parameter int LANES     = 4,
  parameter int NSLOTS    = 16,
  parameter int SLOT_BITS = 4,
  parameter int CARD_SLOT = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LANES-1:0]  bus_wstrb,
  input logic              bus_rstrb,
  input logic [NSLOTS-1:0] slot_sel_n,
  input logic              bus_ready,
  input logic              bus_rdata_oe,
  input logic              irq_n
);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~slot_sel_n));

  // R1
  sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_addr[ADDR_W-1 -: 4] != 4'h4) || (bus_wstrb == '0 && !bus_rstrb)) |-> (&slot_sel_n));

  // R6
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ready) |-> $past(!slot_sel_n[CARD_SLOT]));

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && !slot_sel_n[CARD_SLOT]) |=> bus_ready);

  // R5
  oe_window_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata_oe |-> (bus_addr[ADDR_W-1 -: 4] == 4'h4 &&
                      bus_addr[16 +: SLOT_BITS] == SLOT_BITS'(CARD_SLOT)));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!bus_ready && irq_n));
endmodule

bind slot_card_target slot_card_chk #(
  .ADDR_W(ADDR_W), .LANES(DATA_W/8), .NSLOTS(2**SLOT_BITS),
  .SLOT_BITS(SLOT_BITS), .CARD_SLOT(CARD_SLOT)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wstrb(bus_wstrb),
  .bus_rstrb(bus_rstrb), .slot_sel_n(slot_sel_n), .bus_ready(bus_ready),
  .bus_rdata_oe(bus_rdata_oe), .irq_n(irq_n)
);

// File: tb/sim_slot_card_target.sv
module sim_slot_card_target;
  localparam int CARD = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic [3:0]  bus_wstrb = '0;
  logic        bus_rstrb = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  src_evt = '0;
  logic [15:0] slot_sel_n;
  logic        bus_ready, bus_rdata_oe, irq_n;
  logic [31:0] bus_rdata, ctrl_q;

  slot_card_target #(.CARD_SLOT(CARD)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wstrb(bus_wstrb),
    .bus_rstrb(bus_rstrb), .bus_wdata(bus_wdata), .src_evt(src_evt),
    .slot_sel_n(slot_sel_n), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .irq_n(irq_n), .ctrl_q(ctrl_q)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, rises = 0;
  logic rdy_prev = 1'b0;
  logic [31:0] m_ctrl = '0, m_scr = '0;
  logic [7:0]  m_pend = '0, m_ien = '0;

  always @(negedge clk) begin
    if (bus_ready && !rdy_prev) rises++;
    rdy_prev <= bus_ready;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] lmask(logic [3:0] wl);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{wl[l]}};
    return m;
  endfunction

  function automatic logic [15:0] exp_sel(logic [23:0] a, logic [3:0] wl, logic rd);
    if (a[23:20] == 4'h4 && (wl != 0 || rd)) return ~(16'h1 << a[19:16]);
    return 16'hFFFF;
  endfunction

  function automatic logic [31:0] exp_read(logic [15:0] off);
    case (off)
      16'h0000: return m_ctrl;
      16'h0004: return {24'h0, m_pend};
      16'h0008: return {24'h0, m_ien};
      16'h000C: return m_scr;
      default:  return 32'h0;
    endcase
  endfunction

  task automatic bus_acc(logic [23:0] a, logic [3:0] wl, logic rd,
                         logic [31:0] wd, logic [7:0] ev);
    logic hit;
    logic [31:0] m, rexp;
    int r0;
    @(negedge clk);
    bus_addr = a; bus_wstrb = wl; bus_rstrb = rd; bus_wdata = wd; src_evt = ev;
    #1;
    r0 = rises;
    chk("R1/R2 select decode", {16'h0, slot_sel_n}, {16'h0, exp_sel(a, wl, rd)});
    hit = (a[23:20] == 4'h4) && (a[19:16] == 4'(CARD)) && (wl != 0 || rd);
    rexp = exp_read(a[15:0]);
    m = lmask(wl);
    @(negedge clk);
    src_evt = '0;
    if (hit && wl != 0) begin
      case (a[15:0])
        16'h0000: m_ctrl = (m_ctrl & ~m) | (wd & m);
        16'h0004: m_pend = m_pend & ~(wd[7:0] & m[7:0]);
        16'h0008: m_ien  = (m_ien & ~m[7:0]) | (wd[7:0] & m[7:0]);
        16'h000C: m_scr  = (m_scr & ~m) | (wd & m);
        default: ;
      endcase
    end
    m_pend = m_pend | ev;
    chk("R6/R3 ready after select", {31'h0, bus_ready}, {31'h0, hit});
    if (hit && rd) begin
      chk("R5/R7 read data with ready", bus_rdata, rexp);
      chk("R5 read enable", {31'h0, bus_rdata_oe}, 32'h1);
    end
    @(negedge clk);
    chk("R6 ready held", {31'h0, bus_ready}, {31'h0, hit});
    bus_wstrb = '0; bus_rstrb = 1'b0;
    #1;
    chk("R5 read enable off", {31'h0, bus_rdata_oe}, 32'h0);
    chk("R1 idle selects", {16'h0, slot_sel_n}, 32'h0000FFFF);
    @(negedge clk);
    #1;
    chk("R6 ready dropped", {31'h0, bus_ready}, 32'h0);
    chk("R6 one pulse", 32'(rises - r0), {31'h0, hit});
    chk("R9 irq line", {31'h0, irq_n}, {31'h0, ~|(m_pend & m_ien)});
    chk("R4 control port", ctrl_q, m_ctrl);
  endtask

  function automatic logic [23:0] card_addr(logic [15:0] off);
    return {4'h4, 4'(CARD), off};
  endfunction

  task automatic pulse_evt(logic [7:0] v);
    @(negedge clk);
    src_evt = v;
    @(negedge clk);
    src_evt = '0;
    m_pend = m_pend | v;
    chk("R9 irq after event", {31'h0, irq_n}, {31'h0, ~|(m_pend & m_ien)});
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED_0C4D));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready low", {31'h0, bus_ready}, 32'h0);
    chk("R10 irq high", {31'h0, irq_n}, 32'h1);
    chk("R10 control zero", ctrl_q, 32'h0);
    for (int k = 0; k < 4; k++) bus_acc(card_addr(16'(k * 4)), 4'h0, 1'b1, '0, '0);

    // R4 full and partial lane writes
    bus_acc(card_addr(16'h0000), 4'hF, 1'b0, 32'hA1B2C3D4, '0);
    bus_acc(card_addr(16'h0000), 4'b0101, 1'b0, 32'h11223344, '0);
    bus_acc(card_addr(16'h0000), 4'h0, 1'b1, '0, '0);
    bus_acc(card_addr(16'h000C), 4'b1000, 1'b0, 32'hEE000000, '0);
    bus_acc(card_addr(16'h000C), 4'h0, 1'b1, '0, '0);

    // R7 unused offsets ignore writes and read zero
    bus_acc(card_addr(16'h0010), 4'hF, 1'b0, 32'hFFFFFFFF, '0);
    bus_acc(card_addr(16'h0010), 4'h0, 1'b1, '0, '0);
    bus_acc(card_addr(16'h1000), 4'h0, 1'b1, '0, '0);
    bus_acc(card_addr(16'h0000), 4'h0, 1'b1, '0, '0);

    // R3 other slot and non-IO region leave the card untouched
    bus_acc({4'h4, 4'(CARD + 1), 16'h0000}, 4'hF, 1'b0, 32'h0BADF00D, '0);
    bus_acc({4'h3, 4'(CARD), 16'h000C}, 4'hF, 1'b0, 32'h0BADF00D, '0);
    bus_acc(card_addr(16'h0000), 4'h0, 1'b1, '0, '0);
    bus_acc(card_addr(16'h000C), 4'h0, 1'b1, '0, '0);

    // R2 every slot number
    for (int s = 0; s < 16; s++) bus_acc({4'h4, 4'(s), 16'h0008}, 4'h0, 1'b1, '0, '0);

    // R8 R9 interrupts
    pulse_evt(8'h21);
    bus_acc(card_addr(16'h0004), 4'h0, 1'b1, '0, '0);
    bus_acc(card_addr(16'h0008), 4'h1, 1'b0, 32'h00000001, '0);
    bus_acc(card_addr(16'h0004), 4'h1, 1'b0, 32'h00000001, '0);
    bus_acc(card_addr(16'h0008), 4'h1, 1'b0, 32'h000000FF, '0);
    bus_acc(card_addr(16'h0004), 4'h1, 1'b0, 32'h00000020, 8'h20);
    bus_acc(card_addr(16'h0004), 4'h0, 1'b1, '0, '0);
    bus_acc(card_addr(16'h0004), 4'h1, 1'b0, 32'h000000FF, '0);
    bus_acc(card_addr(16'h0004), 4'h0, 1'b1, '0, '0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [23:0] a;
      logic [15:0] off;
      logic [3:0] wl;
      logic rd;
      int pick;
      pick = int'($urandom_range(0, 5));
      off = (pick < 4) ? 16'(pick * 4) : 16'($urandom);
      a[15:0]  = off;
      a[19:16] = ($urandom_range(0, 9) < 6) ? 4'(CARD) : 4'($urandom);
      a[23:20] = ($urandom_range(0, 9) < 9) ? 4'h4 : 4'($urandom);
      rd = $urandom_range(0, 1) == 1;
      wl = rd ? 4'h0 : 4'($urandom_range(1, 15));
      bus_acc(a, wl, rd, $urandom, ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h0);
      if ($urandom_range(0, 5) == 0) pulse_evt(8'($urandom));
    end

    finish_up();
  end
endmodule